// File: doc/BRIEF.md
# Instruction Cache Fetch and Refill Unit

This block is the fetch side of a set-associative instruction cache with eight ways per set. A fetch address is looked up against every way of its set at once. On a hit, the 16-byte group of four 32-bit instructions that the address selects is returned one cycle later. On a miss, the block asks the memory side for the 32-byte line. The whole line comes back in one transfer, and the requested group is returned in the cycle after that transfer.

The block is nonblocking. While one refill is outstanding, fetches that hit keep being accepted and answered. A fetch to the line that is already being fetched is attached to the outstanding request, and no new request is sent. A miss to any other line is held back with `fetch_ready_o` low until the refill completes. Each way of each set can be locked. A refill is placed only in an unlocked way. When every way of the set is locked, or when the cache is disabled, the line is passed to the fetch side without being stored. A disabled cache treats every fetch as a miss and sends it to memory as a cacheable request.

Top module: `icf_fill_unit`

## Requirements
- R1: After reset `resp_valid_o` and `mem_req_o` are low, and `fetch_ready_o` is high.
- R2: A fetch accepted (`fetch_valid_i` and `fetch_ready_o` high at a clock edge) that hits while enabled raises `resp_valid_o` in the next cycle. `resp_addr_o` is the fetch address with bits 3:0 cleared. `resp_data_o` is line bits 127:0 when address bit 4 is 0, and line bits 255:128 when it is 1.
- R3: An accepted miss raises `mem_req_o` for exactly one cycle, in the cycle after acceptance, with `mem_addr_o` equal to the fetch address with bits 4:0 cleared. The requested group is presented the cycle after the edge that samples `mem_rvalid_i` high. A later fetch to that line hits and sends no request.
- R4: While a refill is outstanding, fetches that hit are accepted and answered before the refill.
- R5: Only one refill is outstanding. A miss to a different line sees `fetch_ready_o` low and causes no second request until the refill returns.
- R6: A fetch to the line under refill is accepted without a new request, and only one such fetch is held. It is answered in the cycle after the primary response, from the refilled line. While that merged fetch waits, a further fetch to the same line is stalled.
- R7: A refill goes to the lowest-numbered way that is both invalid and unlocked. If there is none, it goes to the first unlocked way at or after a per-set rotating pointer, and the pointer then advances past that way.
- R8: Asserting `lock_we_i` replaces the lock mask of set `lock_set_i` with `lock_ways_i` (bit w locks way w). Locked lines keep hitting and are never replaced.
- R9: When all ways of the set are locked, a miss is answered from memory without storing the line, so a repeat fetch misses again.
- R10: While `enable_i` is low, every fetch misses and is answered from memory without storing the line, even if the line is present. Stored contents hit again once `enable_i` returns high.
- R11: `fetch_ready_o` is low in any cycle where `mem_rvalid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Cache enable; low bypasses the arrays |
| lock_we_i | input | 1 | Write the lock mask of one set |
| lock_set_i | input | $clog2(SETS) | Set whose lock mask is written |
| lock_ways_i | input | WAYS | New lock mask, one bit per way |
| fetch_valid_i | input | 1 | Fetch request valid |
| fetch_addr_i | input | ADDR_W | Fetch byte address |
| fetch_ready_o | output | 1 | Fetch can be accepted this cycle |
| resp_valid_o | output | 1 | Instruction group valid |
| resp_addr_o | output | ADDR_W | 16-byte aligned address of the group |
| resp_data_o | output | 128 | Four instructions |
| mem_req_o | output | 1 | One-cycle line read request |
| mem_addr_o | output | ADDR_W | 32-byte aligned line address |
| mem_rvalid_i | input | 1 | Refill line valid |
| mem_rdata_i | input | 256 | Whole refill line |

## Verification
The bench builds the block with four sets and eight ways. With only four sets, distinct tags are easy to steer into the same set. This makes it possible to fill all eight ways of one set in a few refills, to lock seven of them and watch the eighth get replaced, and to lock all eight and see the line forwarded without being stored. The 32-bit address and 256-bit line keep their defaults, so the choice of half-line and the alignment of the response address are checked at their real widths.

// File: rtl/icf_pkg.sv
package icf_pkg;
  localparam int unsigned LINE_BYTES = 32;
  localparam int unsigned LINE_W     = LINE_BYTES * 8;
  localparam int unsigned GROUP_W    = LINE_W / 2;

  typedef logic [LINE_W-1:0]  line_t;
  typedef logic [GROUP_W-1:0] group_t;

  function automatic group_t pick_group(input line_t l, input logic upper);
    return upper ? l[LINE_W-1 -: GROUP_W] : l[GROUP_W-1:0];
  endfunction
endpackage

// File: rtl/icf_tag_store.sv
module icf_tag_store #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 8,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 23,
  parameter int unsigned WAY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [WAY_W-1:0] lk_way_o,
  input  logic [IDX_W-1:0] al_idx_i,
  output logic [WAYS-1:0]  al_valid_o,
  output logic [WAYS-1:0]  al_lock_o,
  output logic [WAY_W-1:0] al_ptr_o,
  input  logic             wr_en_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             lock_we_i,
  input  logic [IDX_W-1:0] lock_idx_i,
  input  logic [WAYS-1:0]  lock_ways_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  lock_q  [SETS];
  logic [WAY_W-1:0] ptr_q   [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lk_idx_i][w] && (tag_q[lk_idx_i][w] == lk_tag_i);
  end

  always_comb begin
    lk_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) lk_way_o = WAY_W'(w);
    end
  end
  assign lk_hit_o   = |match;
  assign al_valid_o = valid_q[al_idx_i];
  assign al_lock_o  = lock_q[al_idx_i];
  assign al_ptr_o   = ptr_q[al_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        lock_q[s]  <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      if (wr_en_i) begin
        valid_q[al_idx_i][wr_way_i] <= 1'b1;
        ptr_q[al_idx_i]             <= wr_way_i + WAY_W'(1);
      end
      if (lock_we_i) lock_q[lock_idx_i] <= lock_ways_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[al_idx_i][wr_way_i] <= wr_tag_i;
  end

  // R8: the victim search never lands on a locked way
  a_r8_write_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !lock_q[al_idx_i][wr_way_i]);
  // R2: a line is never held twice in one set
  a_r2_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/icf_victim_pick.sv
module icf_victim_pick #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned WAY_W = 3
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  lock_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             none_o
);
  logic [WAYS-1:0]  open_w;
  logic             found;
  logic [WAY_W-1:0] cand;

  assign open_w = ~valid_i & ~lock_i;
  assign none_o = &lock_i;

  always_comb begin
    way_o = '0;
    found = 1'b0;
    cand  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && open_w[w]) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
    for (int k = 0; k < WAYS; k++) begin
      cand = ptr_i + WAY_W'(k);
      if (!found && !lock_i[cand]) begin
        way_o = cand;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icf_data_store.sv
module icf_data_store
  import icf_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 8,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned WAY_W = 3
) (
  input  logic             clk_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [WAY_W-1:0] rd_way_i,
  output line_t            rd_line_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  line_t            wr_line_i
);
  line_t mem_q [SETS][WAYS];

  assign rd_line_o = mem_q[rd_idx_i][rd_way_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i][wr_way_i] <= wr_line_i;
  end
endmodule

// File: rtl/icf_fill_unit.sv
module icf_fill_unit
  import icf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 16,
  parameter int unsigned WAYS   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    lock_we_i,
  input  logic [$clog2(SETS)-1:0] lock_set_i,
  input  logic [WAYS-1:0]         lock_ways_i,
  input  logic                    fetch_valid_i,
  input  logic [ADDR_W-1:0]       fetch_addr_i,
  output logic                    fetch_ready_o,
  output logic                    resp_valid_o,
  output logic [ADDR_W-1:0]       resp_addr_o,
  output logic [GROUP_W-1:0]      resp_data_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [LINE_W-1:0]       mem_rdata_i
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int unsigned HSEL  = OFF_W - 1;

  logic [IDX_W-1:0]  f_idx, m_idx;
  logic [TAG_W-1:0]  f_tag, m_tag;
  logic              miss_q, merge_q, mout_q, noalloc_q, req_q;
  logic [ADDR_W-1:0] miss_addr_q, merge_addr_q;
  line_t             buf_q, rd_line;
  logic              resp_valid_q;
  logic [ADDR_W-1:0] resp_addr_q;
  group_t            resp_data_q;
  logic              lk_hit, vic_none;
  logic [WAY_W-1:0]  lk_way, al_ptr, vic_way;
  logic [WAYS-1:0]   al_valid, al_lock;
  logic              hit, same_line, fill, wr_en, acc;

  function automatic logic [ADDR_W-1:0] grp_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:HSEL], {HSEL{1'b0}}};
  endfunction

  assign f_idx = fetch_addr_i[OFF_W +: IDX_W];
  assign f_tag = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign m_idx = miss_addr_q[OFF_W +: IDX_W];
  assign m_tag = miss_addr_q[ADDR_W-1 -: TAG_W];

  icf_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (f_idx),
    .lk_tag_i    (f_tag),
    .lk_hit_o    (lk_hit),
    .lk_way_o    (lk_way),
    .al_idx_i    (m_idx),
    .al_valid_o  (al_valid),
    .al_lock_o   (al_lock),
    .al_ptr_o    (al_ptr),
    .wr_en_i     (wr_en),
    .wr_way_i    (vic_way),
    .wr_tag_i    (m_tag),
    .lock_we_i   (lock_we_i),
    .lock_idx_i  (lock_set_i),
    .lock_ways_i (lock_ways_i)
  );

  icf_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i (al_valid),
    .lock_i  (al_lock),
    .ptr_i   (al_ptr),
    .way_o   (vic_way),
    .none_o  (vic_none)
  );

  icf_data_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_data (
    .clk_i     (clk_i),
    .rd_idx_i  (f_idx),
    .rd_way_i  (lk_way),
    .rd_line_o (rd_line),
    .wr_en_i   (wr_en),
    .wr_idx_i  (m_idx),
    .wr_way_i  (vic_way),
    .wr_line_i (mem_rdata_i)
  );

  assign hit       = enable_i && lk_hit;
  assign same_line = miss_q && (fetch_addr_i[ADDR_W-1:OFF_W] == miss_addr_q[ADDR_W-1:OFF_W]);
  assign fill      = miss_q && mem_rvalid_i;
  assign wr_en     = fill && !noalloc_q && !vic_none;

  // the response register is shared by hits, refills and the merged follow-up
  assign fetch_ready_o = !mem_rvalid_i && !mout_q
                      && !(miss_q && !hit && !same_line)
                      && !(miss_q && !hit && same_line && merge_q);
  assign acc = fetch_valid_i && fetch_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_q       <= 1'b0;
      merge_q      <= 1'b0;
      mout_q       <= 1'b0;
      noalloc_q    <= 1'b0;
      req_q        <= 1'b0;
      miss_addr_q  <= '0;
      merge_addr_q <= '0;
      buf_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_addr_q  <= '0;
      resp_data_q  <= '0;
    end else begin
      req_q        <= acc && !hit && !miss_q;
      resp_valid_q <= (acc && hit) || fill || mout_q;
      mout_q       <= fill && merge_q;
      if (acc && !hit) begin
        if (!miss_q) begin
          miss_q      <= 1'b1;
          miss_addr_q <= fetch_addr_i;
          noalloc_q   <= !enable_i;
        end else begin
          merge_q      <= 1'b1;
          merge_addr_q <= fetch_addr_i;
        end
      end
      if (fill) begin
        miss_q      <= 1'b0;
        merge_q     <= 1'b0;
        if (merge_q) buf_q <= mem_rdata_i;
        resp_addr_q <= grp_align(miss_addr_q);
        resp_data_q <= pick_group(mem_rdata_i, miss_addr_q[HSEL]);
      end else if (mout_q) begin
        resp_addr_q <= grp_align(merge_addr_q);
        resp_data_q <= pick_group(buf_q, merge_addr_q[HSEL]);
      end else if (acc && hit) begin
        resp_addr_q <= grp_align(fetch_addr_i);
        resp_data_q <= pick_group(rd_line, fetch_addr_i[HSEL]);
      end
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_addr_o  = resp_addr_q;
  assign resp_data_o  = resp_data_q;
  assign mem_req_o    = req_q;
  assign mem_addr_o   = {miss_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  a_r3_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r3_fill_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill |=> resp_valid_o);
  a_r5_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_q && !mem_rvalid_i) |=> !mem_req_o);
  a_r6_merge_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mout_q |=> (resp_valid_o && !mout_q));
  a_r10_bypass_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_ready_o && !enable_i) |=> !resp_valid_o);
  a_r11_fill_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> !fetch_ready_o);
endmodule

// File: tb/icf_fill_unit_test.sv
`timescale 1ns/1ps
module icf_fill_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b1;
  logic         lock_we = 1'b0;
  logic [1:0]   lock_set = '0;
  logic [7:0]   lock_ways = '0;
  logic         fetch_valid = 1'b0;
  logic [31:0]  fetch_addr = '0;
  logic         fetch_ready;
  logic         resp_valid;
  logic [31:0]  resp_addr;
  logic [127:0] resp_data;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid = 1'b0;
  logic [255:0] mem_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int req_cnt = 0;
  logic [31:0] last_req = '0;

  logic [31:0]  exp_addr_q [$];
  logic [127:0] exp_data_q [$];
  string        exp_tag_q  [$];

  always #2 clk = ~clk;

  icf_fill_unit #(.ADDR_W(32), .SETS(4), .WAYS(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .lock_we_i(lock_we), .lock_set_i(lock_set), .lock_ways_i(lock_ways),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr), .fetch_ready_o(fetch_ready),
    .resp_valid_o(resp_valid), .resp_addr_o(resp_addr), .resp_data_o(resp_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mk(input int t, input int s, input int h);
    return (32'(t) << 7) | (32'(s) << 5) | (32'(h) << 4);
  endfunction

  function automatic logic [255:0] line_of(input logic [31:0] la, input logic [7:0] g);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = la + 32'(i) + {g, 24'h0};
    return d;
  endfunction

  function automatic logic [127:0] grp(input logic [31:0] a, input logic [7:0] g);
    logic [255:0] d;
    d = line_of(a & ~32'h1f, g);
    return a[4] ? d[255:128] : d[127:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_grp(input logic [31:0] a, input logic [7:0] g, input string req);
    exp_addr_q.push_back(a & ~32'hf);
    exp_data_q.push_back(grp(a, g));
    exp_tag_q.push_back(req);
  endtask

  // monitor: compare each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      req_cnt++;
      last_req = mem_addr;
    end
    if (rst_n && resp_valid) begin
      if (exp_addr_q.size() == 0) begin
        chk(1'b0, "R2 unexpected response", {96'h0, resp_addr}, '0);
      end else begin
        logic [31:0]  ea;
        logic [127:0] ed;
        string        et;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        et = exp_tag_q.pop_front();
        chk(resp_addr == ea, et, {96'h0, resp_addr}, {96'h0, ea});
        chk(resp_data == ed, et, resp_data, ed);
      end
    end
  end

  task automatic fetch(input logic [31:0] a);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    #1;
    while (!fetch_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    fetch_valid = 1'b0;
  endtask

  task automatic reply(input logic [31:0] la, input logic [7:0] g);
    @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = line_of(la, g);
    #1;
    chk(!fetch_ready, "R11", {127'h0, fetch_ready}, '0);
    @(posedge clk);
    #1;
    mem_rvalid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic miss_fill(input logic [31:0] a, input logic [7:0] g, input string req);
    int n0;
    n0 = req_cnt;
    expect_grp(a, g, req);
    fetch(a);
    @(negedge clk);
    #1;
    chk(req_cnt == n0 + 1, req, 128'(req_cnt), 128'(n0 + 1));
    chk(last_req == (a & ~32'h1f), req, {96'h0, last_req}, {96'h0, a & ~32'h1f});
    reply(a & ~32'h1f, g);
    settle();
  endtask

  task automatic hit_chk(input logic [31:0] a, input logic [7:0] g, input string req);
    int n0;
    n0 = req_cnt;
    expect_grp(a, g, req);
    fetch(a);
    settle();
    chk(req_cnt == n0, req, 128'(req_cnt), 128'(n0));
  endtask

  task automatic set_lock(input int s, input logic [7:0] m);
    @(negedge clk);
    lock_we   = 1'b1;
    lock_set  = 2'(s);
    lock_ways = m;
    @(posedge clk);
    #1;
    lock_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(!resp_valid, "R1", {127'h0, resp_valid}, '0);
    chk(!mem_req, "R1", {127'h0, mem_req}, '0);
    chk(fetch_ready, "R1", {127'h0, fetch_ready}, 128'h1);

    // R3 first miss, then R2 hit on the other half
    miss_fill(mk(1, 0, 0), 8'd1, "R3");
    hit_chk(mk(1, 0, 1), 8'd1, "R2");
    hit_chk(mk(1, 0, 0), 8'd1, "R3");

    // R4 hits under an outstanding miss
    n0 = req_cnt;
    fetch(mk(2, 1, 1));
    expect_grp(mk(1, 0, 1), 8'd1, "R4");
    fetch(mk(1, 0, 1));
    expect_grp(mk(1, 0, 0), 8'd1, "R4");
    fetch(mk(1, 0, 0));
    settle();
    chk(req_cnt == n0 + 1, "R4", 128'(req_cnt), 128'(n0 + 1));
    expect_grp(mk(2, 1, 1), 8'd2, "R4");
    reply(mk(2, 1, 0), 8'd2);
    settle();

    // R5 second miss to another line stalls
    n0 = req_cnt;
    fetch(mk(3, 2, 0));
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = mk(4, 3, 0);
    #1;
    chk(!fetch_ready, "R5", {127'h0, fetch_ready}, '0);
    repeat (4) @(negedge clk);
    #1;
    chk(!fetch_ready, "R5", {127'h0, fetch_ready}, '0);
    chk(req_cnt == n0 + 1, "R5", 128'(req_cnt), 128'(n0 + 1));
    fetch_valid = 1'b0;
    expect_grp(mk(3, 2, 0), 8'd3, "R5");
    reply(mk(3, 2, 0), 8'd3);
    settle();
    miss_fill(mk(4, 3, 0), 8'd4, "R5");

    // R6 merge with the outstanding refill
    n0 = req_cnt;
    fetch(mk(5, 1, 0));
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = mk(5, 1, 1);
    #1;
    chk(fetch_ready, "R6", {127'h0, fetch_ready}, 128'h1);
    @(posedge clk);
    #1;
    fetch_valid = 1'b0;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = mk(5, 1, 0);
    #1;
    chk(!fetch_ready, "R6", {127'h0, fetch_ready}, '0);
    fetch_valid = 1'b0;
    chk(req_cnt == n0 + 1, "R6", 128'(req_cnt), 128'(n0 + 1));
    expect_grp(mk(5, 1, 0), 8'd5, "R6");
    expect_grp(mk(5, 1, 1), 8'd5, "R6");
    reply(mk(5, 1, 0), 8'd5);
    settle();
    hit_chk(mk(5, 1, 1), 8'd5, "R6");

    // R7 / R8: fill set 2 (tag 3 already in way 0), lock ways 0..6
    for (int t = 10; t <= 16; t++) miss_fill(mk(t, 2, 0), 8'(t), "R7");
    set_lock(2, 8'h7f);
    miss_fill(mk(20, 2, 1), 8'd20, "R7");
    hit_chk(mk(3, 2, 1), 8'd3, "R8");
    hit_chk(mk(10, 2, 0), 8'd10, "R8");
    hit_chk(mk(20, 2, 0), 8'd20, "R7");
    miss_fill(mk(16, 2, 0), 8'd26, "R7");

    // R9: set 3 fully locked
    set_lock(3, 8'hff);
    hit_chk(mk(4, 3, 1), 8'd4, "R8");
    miss_fill(mk(30, 3, 1), 8'd6, "R9");
    miss_fill(mk(30, 3, 1), 8'd7, "R9");

    // R10: disabled cache bypasses present lines
    enable = 1'b0;
    miss_fill(mk(1, 0, 1), 8'd9, "R10");
    miss_fill(mk(1, 0, 1), 8'd11, "R10");
    enable = 1'b1;
    hit_chk(mk(1, 0, 1), 8'd1, "R10");

    settle();
    chk(exp_addr_q.size() == 0, "R2 missing response", 128'(exp_addr_q.size()), '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule